// File: doc/BRIEF.md
# Compare-Match Timer

This block is an up-counting timer with a small word-addressed register bus. The clock source is selectable: either the block clock, an external slow strobe, or no clock. The selected source is divided by a 12-bit prescaler. The counter then advances once per prescaled tick.

Three compare channels watch the counter and each can raise a status flag. A fourth flag records a counter wrap to zero. Software clears any flag by writing a one to its bit. A single interrupt line is driven from the flags that are enabled, and only while the timer itself is enabled.

The counter runs in one of two modes. In free-running mode it wraps at all ones. In restart mode it returns to zero after matching compare channel 1. The enable-mode bit decides whether turning the timer on resumes the held count or starts it from zero. A self-clearing soft-reset bit reinitialises the timing state but keeps the clock-source and mode selection.

The counter width is a parameter. It defaults to 32 bits, and "all ones" below means all ones at that width.

Top module: `cmt_timer`

## Requirements
- R1: The registers sit at word offsets 0 to 9 in this order: control, prescaler, status, interrupt enable, compare 1, compare 2, compare 3, capture 1, capture 2, counter.
  - Both capture offsets and any offset above 9 read zero.
  - Writes to the counter and capture offsets have no effect.
- R2: The control register discards writes to bits 2, 4 and 14:10, and those bits read zero.
  - Bit 15 is soft reset. It reads back as one for exactly the one cycle after it is written, then clears itself.
- R3: Control bits 8:6 select the clock source.
  - Codes 001 and 010 tick on every block clock.
  - Code 100 ticks on each cycle where `slow_tick_i` is high.
  - Every other code gives no ticks, and the counter holds.
- R4: The prescaler register keeps only its low 12 bits, value P. The counter advances once every P+1 source ticks.
- R5: With control bit 9 set (free-running), the counter steps by one per prescaled tick and wraps from all ones to zero. A step from all ones to zero sets status bit 5.
- R6: With control bit 9 clear (restart mode), a counter that holds the value of compare 1 returns to zero on the next prescaled tick, not to that value plus one.
- R7: Status bits 0, 1 and 2 belong to compares 1, 2 and 3.
  - A compare flag is set by the prescaled tick that ends a count period in which the counter equalled that compare value.
  - Channels that match on the same tick set their flags together.
- R8: Writing the status register clears each of its low 6 bits written as one. Bits written as zero keep their value.
- R9: The interrupt enable register uses the status bit positions. `irq_o` is high exactly when control bit 0 is set and status AND interrupt enable is nonzero.
- R10: Writing compare 1 in restart mode forces the counter to zero. In free-running mode the same write leaves the count running.
- R11: Control bit 0 is enable, and bit 1 is enable-mode.
  - A 0-to-1 transition of bit 0 with bit 1 set restarts the counter at zero.
  - The same transition with bit 1 clear resumes from the held value.
  - Clearing bit 0 freezes the counter.
- R12: A control write with bit 15 set has these effects:
  - It clears control bits 5:0 and keeps the clock-source and mode bits.
  - It zeroes status, prescaler, interrupt enable and the counter.
  - It sets all three compares to all ones.
- R13: After the hardware reset, every register reads zero except the compares, which read all ones, and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock; also the main count source |
| rst_ni | input | 1 | Active-low asynchronous reset |
| slow_tick_i | input | 1 | One-cycle strobe from a slow reference, already synchronised |
| sel_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 4 | Word offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from `addr_i` |
| irq_o | output | 1 | Level interrupt |

## Verification
Every internal state of this block can be read back one cycle after it changes.

A wrong prescaler phase shows up as a counter value that is off by one at the exact multiple of P+1 where the bench samples it. A stale clear-on-restart path leaves a nonzero count right after the enable write or the compare-1 write. A misplaced match or wrap flag appears in the status read and on `irq_o` in the cycle after the tick that should have set it.

The corner cases that are hardest to see are the ones that only show at specific cycles:
- two channels matching on the same tick;
- the all-ones wrap, where every compare also matches at its reset value;
- a one-cycle soft-reset pulse.

For these the bench samples at those exact cycles.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  localparam int unsigned DW   = 32;
  localparam int unsigned AW   = 4;
  localparam int unsigned STW  = 6;
  localparam int unsigned NCMP = 3;

  localparam logic [AW-1:0] RA_CTRL = 4'd0;
  localparam logic [AW-1:0] RA_PRE  = 4'd1;
  localparam logic [AW-1:0] RA_STS  = 4'd2;
  localparam logic [AW-1:0] RA_IEN  = 4'd3;
  localparam logic [AW-1:0] RA_CMP0 = 4'd4;
  localparam logic [AW-1:0] RA_CNT  = 4'd9;

  localparam int unsigned CB_EN   = 0;
  localparam int unsigned CB_EMOD = 1;
  localparam int unsigned CB_SRC  = 6;
  localparam int unsigned CB_FREE = 9;
  localparam int unsigned CB_SRST = 15;
  localparam int unsigned SB_ROLL = 5;

  localparam logic [DW-1:0] CTRL_WMASK  = 32'hFFFF_83EB;
  localparam logic [DW-1:0] CTRL_SRST_K = 32'hFFFF_FFC0;

  typedef enum logic [1:0] {SRC_NONE, SRC_MAIN, SRC_SLOW} src_e;

  function automatic src_e src_decode(logic [2:0] code);
    case (code)
      3'b001, 3'b010: return SRC_MAIN;
      3'b100:         return SRC_SLOW;
      default:        return SRC_NONE;
    endcase
  endfunction
endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler #(
  parameter int unsigned PW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          clr_i,
  input  logic          src_tick_i,
  input  logic [PW-1:0] div_i,
  output logic          tick_o
);
  logic [PW-1:0] pre_q;

  // >= so that lowering the divisor mid-period cannot strand the phase
  assign tick_o = run_i & src_tick_i & (pre_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pre_q <= '0;
    else if (!run_i || clr_i)   pre_q <= '0;
    else if (src_tick_i)        pre_q <= tick_o ? '0 : pre_q + 1'b1;
  end

  AST_PRE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> pre_q == '0) else $error("prescaler phase not reset"); // R4
endmodule

// File: rtl/cmt_counter.sv
module cmt_counter #(
  parameter int unsigned W = 32,
  parameter int unsigned N = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                tick_i,
  input  logic                restart_i,
  input  logic [N-1:0][W-1:0] cmp_i,
  output logic [W-1:0]        cnt_o,
  output logic [N-1:0]        match_o,
  output logic                wrap_o
);
  logic [W-1:0] cnt_q;
  logic         reload;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign match_o[i] = tick_i & (cnt_q == cmp_i[i]);
  end

  assign wrap_o = tick_i & (&cnt_q);
  assign reload = restart_i & match_o[0];
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (tick_i)  cnt_q <= reload ? '0 : cnt_q + 1'b1;
  end

  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !clr_i |=> $stable(cnt_q)) else $error("count moved without tick"); // R11
  AST_RESTART_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !clr_i && restart_i && (cnt_q == cmp_i[0]) |=> cnt_q == '0)
    else $error("restart missed"); // R6
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !clr_i && !reload |=> cnt_q == $past(cnt_q) + W'(1))
    else $error("bad step"); // R5
endmodule

// File: rtl/cmt_timer.sv
module cmt_timer
  import cmt_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned PRE_W = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          slow_tick_i,
  input  logic          sel_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  logic [DW-1:0]               ctrl_q;
  logic [PRE_W-1:0]            pre_q;
  logic [STW-1:0]              sts_q, ien_q, sts_set, sts_clr;
  logic [NCMP-1:0][CNT_W-1:0]  cmp_q;
  logic [CNT_W-1:0]            cnt;
  logic [NCMP-1:0]             match;
  logic                        wrap, src_tick, ptick;
  logic                        wr, wr_ctrl, srst_now, en_restart, cmp0_restart, cnt_clr;

  assign wr           = sel_i & we_i;
  assign wr_ctrl      = wr && (addr_i == RA_CTRL);
  assign srst_now     = wr_ctrl && wdata_i[CB_SRST];
  assign en_restart   = wr_ctrl && !srst_now && wdata_i[CB_EN] && !ctrl_q[CB_EN] && wdata_i[CB_EMOD];
  assign cmp0_restart = wr && (addr_i == RA_CMP0) && !ctrl_q[CB_FREE];
  assign cnt_clr      = srst_now | en_restart | cmp0_restart;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ctrl_q <= '0;
    else if (wr_ctrl)         ctrl_q <= srst_now ? (wdata_i & CTRL_WMASK & CTRL_SRST_K)
                                                 : (wdata_i & CTRL_WMASK);
    else if (ctrl_q[CB_SRST]) ctrl_q[CB_SRST] <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      ien_q <= '0;
    end else if (srst_now) begin
      pre_q <= '0;
      ien_q <= '0;
    end else if (wr) begin
      if (addr_i == RA_PRE) pre_q <= wdata_i[PRE_W-1:0];
      if (addr_i == RA_IEN) ien_q <= wdata_i[STW-1:0];
    end
  end

  for (genvar i = 0; i < NCMP; i++) begin : g_cmp_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     cmp_q[i] <= '1;
      else if (srst_now)                               cmp_q[i] <= '1;
      else if (wr && (addr_i == RA_CMP0 + AW'(i)))     cmp_q[i] <= wdata_i[CNT_W-1:0];
    end
  end

  always_comb begin
    sts_set = '0;
    sts_set[NCMP-1:0] = match;
    sts_set[SB_ROLL]  = wrap;
    sts_clr = (wr && (addr_i == RA_STS)) ? wdata_i[STW-1:0] : '0;
  end

  // a flag raised in the same cycle as its clear wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sts_q <= '0;
    else if (srst_now) sts_q <= '0;
    else               sts_q <= (sts_q & ~sts_clr) | sts_set;
  end

  always_comb begin
    unique case (src_decode(ctrl_q[CB_SRC +: 3]))
      SRC_MAIN: src_tick = 1'b1;
      SRC_SLOW: src_tick = slow_tick_i;
      default:  src_tick = 1'b0;
    endcase
  end

  cmt_prescaler #(.PW(PRE_W)) u_pre (
    .clk_i, .rst_ni,
    .run_i      (ctrl_q[CB_EN]),
    .clr_i      (cnt_clr),
    .src_tick_i (src_tick),
    .div_i      (pre_q),
    .tick_o     (ptick)
  );

  cmt_counter #(.W(CNT_W), .N(NCMP)) u_cnt (
    .clk_i, .rst_ni,
    .clr_i     (cnt_clr),
    .tick_i    (ptick),
    .restart_i (!ctrl_q[CB_FREE]),
    .cmp_i     (cmp_q),
    .cnt_o     (cnt),
    .match_o   (match),
    .wrap_o    (wrap)
  );

  always_comb begin
    rdata_o = '0;
    if (sel_i) begin
      case (addr_i)
        RA_CTRL:      rdata_o = ctrl_q;
        RA_PRE:       rdata_o[PRE_W-1:0] = pre_q;
        RA_STS:       rdata_o[STW-1:0] = sts_q;
        RA_IEN:       rdata_o[STW-1:0] = ien_q;
        4'd4:         rdata_o[CNT_W-1:0] = cmp_q[0];
        4'd5:         rdata_o[CNT_W-1:0] = cmp_q[1];
        4'd6:         rdata_o[CNT_W-1:0] = cmp_q[2];
        RA_CNT:       rdata_o[CNT_W-1:0] = cnt;
        default:      rdata_o = '0;
      endcase
    end
  end

  assign irq_o = ctrl_q[CB_EN] & |(sts_q & ien_q);

  AST_SRST_SELFCLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q[CB_SRST] && !wr_ctrl |=> !ctrl_q[CB_SRST]) else $error("soft reset stuck"); // R2
  AST_SRST_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q[CB_SRST] |-> (sts_q == '0) && (ien_q == '0) && (pre_q == '0) && (cnt == '0)
                        && !ctrl_q[CB_EN] && (&cmp_q)) else $error("soft reset state"); // R12
  AST_ROLL_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap && !srst_now |=> sts_q[SB_ROLL]) else $error("rollover flag missed"); // R5
  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_q == '0) |-> !irq_o) else $error("irq without flag"); // R9
endmodule

// File: tb/cmt_timer_bench.sv
module cmt_timer_bench;
  localparam int unsigned CW = 8;
  localparam logic [31:0] ONES = 32'h0000_00FF;

  logic        clk = 1'b0, rst_ni = 1'b0, slow_tick = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq;
  int          n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  cmt_timer #(.CNT_W(CW), .PRE_W(12)) u_cmt_timer (
    .clk_i(clk), .rst_ni(rst_ni), .slow_tick_i(slow_tick),
    .sel_i(sel), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  // caller stands at a falling edge; exactly one rising edge elapses
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    sel = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    sel = 1'b0;
  endtask

  task automatic rchk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset_state;
    rchk("R13 ctrl", 4'd0, 32'h0);
    rchk("R13 pre", 4'd1, 32'h0);
    rchk("R13 sts", 4'd2, 32'h0);
    rchk("R13 ien", 4'd3, 32'h0);
    rchk("R13 cmp1", 4'd4, ONES);
    rchk("R13 cmp2", 4'd5, ONES);
    rchk("R13 cmp3", 4'd6, ONES);
    rchk("R13 cnt", 4'd9, 32'h0);
    chk("R13 irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_map_and_mask;
    wr(4'd0, 32'h0000_7FFF);
    rchk("R2 ctrl mask", 4'd0, 32'h0000_03EB);
    wait_cyc(10);
    rchk("R3 no-clock code holds", 4'd9, 32'h0);
    wr(4'd0, 32'h0);
    wr(4'd9, 32'h55);
    rchk("R1 counter read-only", 4'd9, 32'h0);
    wr(4'd7, 32'h12);
    rchk("R1 capture1 zero", 4'd7, 32'h0);
    rchk("R1 capture2 zero", 4'd8, 32'h0);
    rchk("R1 unmapped zero", 4'd12, 32'h0);
  endtask

  task automatic t_freerun;
    wr(4'd1, 32'h0);
    wr(4'd0, 32'h0000_0243);
    rchk("R11 enable restart", 4'd9, 32'h0);
    wait_cyc(10);
    rchk("R3 main clock count", 4'd9, 32'd10);
    wait_cyc(245);
    rchk("R5 at all ones", 4'd9, 32'd255);
    rchk("R5 no flag yet", 4'd2, 32'h0);
    wait_cyc(1);
    rchk("R5 wrapped", 4'd9, 32'h0);
    rchk("R7 R5 flags together", 4'd2, 32'h27);
    wr(4'd2, 32'h01);
    rchk("R8 clear one", 4'd2, 32'h26);
    wr(4'd2, 32'h26);
    rchk("R8 clear rest", 4'd2, 32'h0);
  endtask

  task automatic t_restart;
    wr(4'd0, 32'h0);
    wr(4'd2, 32'h3F);
    wr(4'd3, 32'h03);
    wr(4'd5, 32'd5);
    wr(4'd4, 32'd5);
    wr(4'd0, 32'h0000_0043);
    rchk("R6 start", 4'd9, 32'h0);
    wait_cyc(5);
    rchk("R6 at compare", 4'd9, 32'd5);
    rchk("R7 before tick", 4'd2, 32'h0);
    chk("R9 irq low", {31'h0, irq}, 32'h0);
    wait_cyc(1);
    rchk("R6 back to zero", 4'd9, 32'h0);
    rchk("R7 two channels", 4'd2, 32'h03);
    chk("R9 irq high", {31'h0, irq}, 32'h1);
    wait_cyc(2);
    wr(4'd4, 32'd9);
    rchk("R10 restart-mode compare write", 4'd9, 32'h0);
    wr(4'd0, 32'h0000_0042);
    chk("R9 gated by enable", {31'h0, irq}, 32'h0);
    rchk("R9 flags kept", 4'd2, 32'h03);
    wr(4'd0, 32'h0000_0243);
    wait_cyc(5);
    rchk("R10 pre", 4'd9, 32'd5);
    wr(4'd4, 32'h30);
    rchk("R10 freerun compare write", 4'd9, 32'd6);
  endtask

  task automatic t_prescale;
    logic [31:0] c;
    wr(4'd0, 32'h0);
    wr(4'd1, 32'h0000_F003);
    rchk("R4 width", 4'd1, 32'h3);
    wr(4'd0, 32'h0000_0243);
    wait_cyc(11);
    rchk("R4 before period", 4'd9, 32'd2);
    wait_cyc(1);
    rchk("R4 at period", 4'd9, 32'd3);
    wr(4'd0, 32'h0000_0242);
    rd(4'd9, c);
    wait_cyc(20);
    rchk("R11 frozen", 4'd9, c);
    wr(4'd0, 32'h0000_0241);
    wait_cyc(4);
    rchk("R11 resume", 4'd9, c + 32'd1);
    wr(4'd0, 32'h0000_0240);
    wr(4'd0, 32'h0000_0243);
    rchk("R11 enable-mode restart", 4'd9, 32'h0);
  endtask

  task automatic t_soft_reset;
    wr(4'd3, 32'h21);
    wr(4'd4, 32'h10);
    wait_cyc(9);
    wr(4'd0, 32'h0000_8243);
    rchk("R2 R12 srst visible", 4'd0, 32'h0000_8240);
    wait_cyc(1);
    rchk("R2 srst self-clear", 4'd0, 32'h0000_0240);
    rchk("R12 pre", 4'd1, 32'h0);
    rchk("R12 sts", 4'd2, 32'h0);
    rchk("R12 ien", 4'd3, 32'h0);
    rchk("R12 cmp1", 4'd4, ONES);
    rchk("R12 cmp2", 4'd5, ONES);
    rchk("R12 cmp3", 4'd6, ONES);
    rchk("R12 cnt", 4'd9, 32'h0);
  endtask

  task automatic t_slow;
    wr(4'd0, 32'h0);
    wr(4'd0, 32'h0000_0103);
    wait_cyc(10);
    rchk("R3 slow idle", 4'd9, 32'h0);
    for (int i = 0; i < 3; i++) begin
      slow_tick = 1'b1;
      @(negedge clk);
      slow_tick = 1'b0;
      wait_cyc(2);
    end
    rchk("R3 slow strobes", 4'd9, 32'd3);
    wr(4'd0, 32'h0);
    wr(4'd0, 32'h0000_0083);
    wait_cyc(7);
    rchk("R3 code 010", 4'd9, 32'd7);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_map_and_mask();
    t_freerun();
    t_restart();
    t_prescale();
    t_soft_reset();
    t_slow();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule